// File: doc/BRIEF.md
# Double-Rate Pad Output Stage

This block drives one memory-interface pin, either a data line or a strobe line, at twice the clock rate. Each clock period it accepts two single-rate values on the system clock: one for the half-cycle when the clock is high and one for the half-cycle when the clock is low. The clock itself selects between them at the pin, so two values leave the pin in every period. For write traffic the clock is expected to be a copy of the system clock shifted by -90 degrees. Producing that shifted clock is outside this block.

The tri-state control uses the same two-register arrangement as the data path. The request is active low and is taken on the rising edge. A second register, clocked on the falling edge, holds the pin in high impedance for one extra half-cycle. When the block drives a strobe pin, that half-cycle is the write preamble the memory expects. The window closes at the first rising edge that sees the request released. The pin is modelled behaviourally as a tri-state driver.

Top module: `ddr_out_cell`

## Requirements
- R1: While rst_n is low at a rising edge, the pad is undriven (pad_en = 0) through the following high and low half-cycles. rst_n is sampled synchronously on both clock edges.
- R2: When driven, during the high phase the pad equals the din_hi value sampled at the most recent rising edge.
- R3: When driven, during the low phase the pad equals the din_lo value sampled at the rising edge that began the same period.
- R4: For a run of consecutive driven periods, the pad carries the sequence hi0, lo0, hi1, lo1, and so on, in that order.
- R5: oe_req_n is active low. A value of 1 sampled at a rising edge leaves the pad undriven after that edge.
- R6: When oe_req_n is first sampled at 0 at rising edge t, the pad stays undriven in the high phase after t and is first driven in the low phase after t, which is half a cycle later.
- R7: When oe_req_n is sampled at 1 at a rising edge that ends a driven window, the pad is undriven from that edge on. There is no trailing half-cycle.
- R8: pad_en is 1 exactly when the pad is driven, and 0 when the pad is high impedance.
- R9: Changes to din_hi and din_lo between rising edges have no effect on the pad until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock; its level also selects the pad half-cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| din_hi | input | W | Value for the high half-cycle |
| din_lo | input | W | Value for the low half-cycle |
| oe_req_n | input | 1 | Active-low drive request |
| pad | inout | W | Tri-state pin |
| pad_en | output | 1 | 1 while the pad is driven |

## Verification
The hardest situation to reach is a window edge that coincides with other events. Examples are a one-period request pulse, where the preamble and the close fall in consecutive half-cycles, and a reset asserted in the middle of a driven burst. The stimulus covers both cases directly: it asserts the request for exactly one period, and later pulls reset low while the request is still held. It also flips the data inputs in the middle of the high phase of one period. This shows that the low-phase value comes from the rising-edge capture and not from the live input.

// File: rtl/ddr_out_pkg.sv
`timescale 1ns/1ps
// Shared constants for the double-rate output stage.
// Assumes the enable path is active low and that reset parks it in the off state.
package ddr_out_pkg;
    localparam logic OE_OFF = 1'b1;   // disabled level of the active-low enable registers
    localparam logic OE_ON  = 1'b0;

    // True when both half-cycle enable stages request drive.
    function automatic logic both_on(input logic rise_q, input logic fall_q);
        return (rise_q == OE_ON) && (fall_q == OE_ON);
    endfunction
endpackage

// File: rtl/hc_pipe.sv
`timescale 1ns/1ps
// Half-cycle pipe: captures d on the rising edge, then re-registers that
// capture on the falling edge. Used for the low-half data and for the enable.
// Assumes rst_n is synchronous to both edges and is held for at least one full period.
module hc_pipe #(
    parameter int   W       = 1,
    parameter logic RST_BIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_r,
    output logic [W-1:0] q_f
);
    localparam logic [W-1:0] RST_VEC = {W{RST_BIT}};

    // Rising-edge capture of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= RST_VEC;
        else        q_r <= d;
    end

    // Falling-edge re-register of the rising capture.
    always_ff @(negedge clk) begin
        if (!rst_n) q_f <= RST_VEC;
        else        q_f <= q_r;
    end

    AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> q_r == $past(d));                                        // R3
    AST_FALL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        q_f == q_r);                                                      // R9
endmodule

// File: rtl/ddr_pad_drv.sv
`timescale 1ns/1ps
// Pad driver: the clock level picks the high-half or low-half value, and
// the enable gates a behavioural tri-state buffer.
// Assumes hi is stable over the high phase and lo is stable over the low phase.
module ddr_pad_drv #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    input  logic         en,
    inout  wire  [W-1:0] pad
);
    logic [W-1:0] sel;

    // Clock-level multiplexer that forms the double-rate stream.
    always_comb sel = clk ? hi : lo;

    assign pad = en ? sel : {W{1'bz}};
endmodule

// File: rtl/ddr_out_cell.sv
`timescale 1ns/1ps
// Double-rate output cell for one DQ or DQS pin. High-half data is held in a
// rising-edge register. Low-half data and the active-low enable each pass
// through a rising-then-falling register pair. The pad is driven only while
// both enable stages are on, so drive starts half a cycle after the request.
// Assumes clk is the -90 degree write clock and that rst_n is synchronous.
module ddr_out_cell
    import ddr_out_pkg::*;
#(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_hi,
    input  logic [W-1:0] din_lo,
    input  logic         oe_req_n,
    inout  wire  [W-1:0] pad,
    output logic         pad_en
);
    logic [W-1:0] hi_q;
    logic [W-1:0] lo_r;
    logic [W-1:0] lo_f;
    logic         oe_r;
    logic         oe_f;

    // Rising-edge capture of the high-half value.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= din_hi;
    end

    hc_pipe #(.W(W), .RST_BIT(1'b0)) u_lo (
        .clk(clk), .rst_n(rst_n), .d(din_lo), .q_r(lo_r), .q_f(lo_f)
    );

    hc_pipe #(.W(1), .RST_BIT(OE_OFF)) u_oe (
        .clk(clk), .rst_n(rst_n), .d(oe_req_n), .q_r(oe_r), .q_f(oe_f)
    );

    // Drive only while both enable stages are on.
    always_comb pad_en = both_on(oe_r, oe_f);

    ddr_pad_drv #(.W(W)) u_drv (
        .clk(clk), .hi(hi_q), .lo(lo_f), .en(pad_en), .pad(pad)
    );

    AST_HI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> hi_q == $past(din_hi));                                  // R2
    AST_DRIVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pad_en |-> !$past(oe_req_n));                                     // R5
    AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_req_n) |=> pad_en);                                      // R6
    AST_LOW_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        lo_f == lo_r);                                                    // R3
endmodule

// File: tb/sim_ddr_out_cell.sv
`timescale 1ns/100ps
module sim_ddr_out_cell;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [0:0] din_hi = '0;
    logic [0:0] din_lo = '0;
    logic oe_req_n = 1'b1;
    wire  [0:0] pad;
    logic pad_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state, updated behaviourally at each edge.
    logic m_hi = 0, m_lo = 0, m_lof = 0, m_oea = 1, m_oeb = 1;
    logic q_exp[$];
    logic q_got[$];

    always #2 clk = ~clk;   // 250 MHz

    ddr_out_cell #(.W(1)) u0 (
        .clk(clk), .rst_n(rst_n), .din_hi(din_hi), .din_lo(din_lo),
        .oe_req_n(oe_req_n), .pad(pad), .pad_en(pad_en)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // One clock period. Inputs are applied in the low phase, and both phases are checked.
    task automatic step(input logic r, input logic h, input logic l,
                        input logic oen, input bit glitch, input bit rec);
        logic drv;
        string tag;
        rst_n = r; din_hi[0] = h; din_lo[0] = l; oe_req_n = oen;
        if (rec) begin q_exp.push_back(h); q_exp.push_back(l); end
        @(posedge clk);
        if (!r) begin m_hi = 0; m_lo = 0; m_oea = 1; end
        else    begin m_hi = h; m_lo = l; m_oea = oen; end
        #1;
        drv = !m_oea && !m_oeb;
        if (!r)              tag = "R1";
        else if (drv)        tag = "R2";
        else if (!m_oea)     tag = "R6";
        else if (!m_oeb)     tag = "R7";
        else                 tag = "R5";
        chk({tag, " R8 pad_en high phase"}, pad_en, drv);
        if (drv) chk({tag, " pad high phase"}, pad[0], m_hi);
        if (rec) q_got.push_back(drv ? pad[0] : 1'bx);
        if (glitch) begin #0.2; din_hi[0] = ~h; din_lo[0] = ~l; end
        @(negedge clk);
        if (!r) begin m_lof = 0; m_oeb = 1; end
        else    begin m_lof = m_lo; m_oeb = m_oea; end
        #1;
        drv = !m_oea && !m_oeb;
        if (!r)          tag = "R1";
        else if (drv)    tag = glitch ? "R9" : "R3";
        else             tag = "R5";
        chk({tag, " R8 pad_en low phase"}, pad_en, drv);
        if (drv) chk({tag, " pad low phase"}, pad[0], m_lof);
        if (rec) q_got.push_back(drv ? pad[0] : 1'bx);
        #0.5;
    endtask

    initial begin
        @(negedge clk); #1.5;
        // R1: reset dominates a held request
        repeat (3) step(0, 1, 1, 0, 0, 0);
        // R5: released reset with the request inactive
        step(1, 1, 0, 1, 0, 0);
        step(1, 0, 1, 1, 0, 0);
        // R6 preamble, then an R4 burst with distinct orderings
        step(1, 1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 1);
        step(1, 0, 1, 0, 0, 1);
        step(1, 1, 1, 0, 0, 1);
        step(1, 0, 0, 0, 0, 1);
        step(1, 0, 1, 0, 0, 1);
        step(1, 1, 0, 0, 0, 1);
        // R9: inputs flip in the middle of the high phase
        step(1, 1, 0, 0, 1, 0);
        step(1, 0, 1, 0, 1, 0);
        // R7: window closes at the release edge
        step(1, 1, 1, 1, 0, 0);
        step(1, 0, 0, 1, 0, 0);
        // one-period pulse: preamble, one driven half, close
        step(1, 1, 0, 0, 0, 0);
        step(1, 0, 1, 1, 0, 0);
        // R1: reset during a driven window
        step(1, 1, 1, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0);
        // mixed traffic
        for (int i = 0; i < 60; i++) begin
            int v = $urandom;
            step(1, v[0], v[1], (v[4:2] == 3'd0), v[5] & v[6], 0);
        end
        // R4: order of the driven stream in the burst
        chk("R4 stream length", q_got.size() == q_exp.size(), 1'b1);
        for (int i = 0; i < q_exp.size() && i < q_got.size(); i++)
            chk("R4 stream order", q_got[i], q_exp[i]);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule